// File: doc/BRIEF.md
# Integer ALU with Multiply and Divide

A purely combinational integer arithmetic unit for a 32-bit scalar core. Two operands and a 5-bit operation code go in, one 32-bit result comes out with no clock and no state. It covers ten base operations: add, subtract, three shifts, two set-less-than compares and three bitwise ops. It also covers eight multiply/divide operations: low product, three high-product variants, and signed and unsigned quotient and remainder.

The operation code's bit 0 separates the two groups. When it is 0 the base unit answers. When it is 1, bit 4 picks the divider (1) or the multiplier (0). Codes that name no operation produce zero, so a decoder can leave the ALU in a harmless state without a separate enable.

Top module: `int_alu`

## Requirements
- R1: ADD (00000) returns a+b and SUB (00010) returns a-b, both modulo 2^32.
- R2: XOR (10000), OR (11000) and AND (11100) return the bitwise function of the operands.
- R3: SLL (00100), SRL (10100) and SRA (10110) shift operand a by b[4:0] only. SRA fills with a[31] and SRL fills with zeros.
- R4: SLT (01000, signed) and SLTU (01100, unsigned) return 1 when a<b and 0 otherwise. Bits 31:1 are always zero.
- R5: MUL (00001) returns the low 32 bits of a×b.
- R6: MULH (00101), MULHU (01001) and MULHSU (01101) return bits 63:32 of the 64-bit product. MULH treats both operands as signed, MULHU treats both as unsigned, and MULHSU treats a as signed and b as unsigned.
- R7: DIV (10001) and DIVU (10101) return the quotient rounded toward zero. REM (11001) and REMU (11101) return a remainder that carries the sign of the dividend.
- R8: With b=0, DIV and DIVU return 0xFFFFFFFF, and REM and REMU return a.
- R9: For DIV with a=0x80000000 and b=0xFFFFFFFF, the result is a. For REM with the same operands, the result is 0.
- R10: Each of the 14 codes not listed in R1 to R7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand (dividend, shift source) |
| b_i | input | 32 | Second operand (divisor, shift amount in bits 4:0) |
| op_i | input | 5 | Operation code |
| result_o | output | 32 | Operation result |

## Verification
The hardest cases to reach are the divider's edges: a zero divisor, and the most negative dividend over minus one. Random operands almost never produce either. The stimulus therefore sweeps every one of the 32 codes over a fixed grid of extreme operands (0, ±1, ±2, both 32-bit extremes, and values around the shift limit), so each edge is hit under every code. Random operand pairs across all codes follow. Every vector is compared against a model built on 64-bit integer arithmetic.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD    = 5'b00000,
    OP_SUB    = 5'b00010,
    OP_SLL    = 5'b00100,
    OP_SLT    = 5'b01000,
    OP_SLTU   = 5'b01100,
    OP_XOR    = 5'b10000,
    OP_SRL    = 5'b10100,
    OP_SRA    = 5'b10110,
    OP_OR     = 5'b11000,
    OP_AND    = 5'b11100,
    OP_MUL    = 5'b00001,
    OP_MULH   = 5'b00101,
    OP_MULHU  = 5'b01001,
    OP_MULHSU = 5'b01101,
    OP_DIV    = 5'b10001,
    OP_DIVU   = 5'b10101,
    OP_REM    = 5'b11001,
    OP_REMU   = 5'b11101
  } alu_op_e;

  localparam int unsigned OP_W = 5;
endpackage

// File: rtl/alu_base.sv
module alu_base
  import int_alu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  logic [SHW-1:0] sh;
  assign sh = b_i[SHW-1:0];

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_SLL:  res_o = a_i << sh;
      OP_SLT:  res_o = XLEN'($signed(a_i) < $signed(b_i));
      OP_SLTU: res_o = XLEN'(a_i < b_i);
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SRL:  res_o = a_i >> sh;
      OP_SRA:  res_o = $unsigned($signed(a_i) >>> sh);
      OP_OR:   res_o = a_i | b_i;
      OP_AND:  res_o = a_i & b_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_mul.sv
module alu_mul
  import int_alu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned PW = 2 * XLEN;

  logic          a_sgn, b_sgn;
  logic [PW-1:0] a_ext, b_ext, prod;

  // one shared multiplier; operand extension selects the signedness
  always_comb begin
    unique case (op_i)
      OP_MULH:   begin a_sgn = 1'b1; b_sgn = 1'b1; end
      OP_MULHSU: begin a_sgn = 1'b1; b_sgn = 1'b0; end
      default:   begin a_sgn = 1'b0; b_sgn = 1'b0; end
    endcase
  end

  assign a_ext = {{XLEN{a_sgn & a_i[XLEN-1]}}, a_i};
  assign b_ext = {{XLEN{b_sgn & b_i[XLEN-1]}}, b_i};
  assign prod  = a_ext * b_ext;

  always_comb begin
    unique case (op_i)
      OP_MUL:                       res_o = prod[XLEN-1:0];
      OP_MULH, OP_MULHU, OP_MULHSU: res_o = prod[PW-1:XLEN];
      default:                      res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_div.sv
module alu_div
  import int_alu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [XLEN-1:0] res_o
);
  logic            sgn, b_zero, q_neg, r_neg;
  logic [XLEN-1:0] a_mag, b_mag, b_div, q_mag, r_mag, quot, rem;

  assign sgn    = (op_i == OP_DIV) || (op_i == OP_REM);
  assign b_zero = (b_i == '0);

  // sign-magnitude: unsigned core, sign fix-up after
  assign a_mag = (sgn && a_i[XLEN-1]) ? (~a_i + 1'b1) : a_i;
  assign b_mag = (sgn && b_i[XLEN-1]) ? (~b_i + 1'b1) : b_i;
  assign b_div = b_zero ? XLEN'(1) : b_mag;
  assign q_mag = a_mag / b_div;
  assign r_mag = a_mag % b_div;

  assign q_neg = sgn && (a_i[XLEN-1] ^ b_i[XLEN-1]);
  assign r_neg = sgn && a_i[XLEN-1];

  // most-negative / -1 wraps back to the dividend with no special case
  assign quot = b_zero ? '1  : (q_neg ? (~q_mag + 1'b1) : q_mag);
  assign rem  = b_zero ? a_i : (r_neg ? (~r_mag + 1'b1) : r_mag);

  always_comb begin
    unique case (op_i)
      OP_DIV, OP_DIVU: res_o = quot;
      OP_REM, OP_REMU: res_o = rem;
      default:         res_o = '0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [OP_W-1:0] op_i,
  output logic [XLEN-1:0] result_o
);
  logic [XLEN-1:0] base_res, mul_res, div_res;

  alu_base #(.XLEN(XLEN)) u_base (.a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(base_res));
  alu_mul  #(.XLEN(XLEN)) u_mul  (.a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(mul_res));
  alu_div  #(.XLEN(XLEN)) u_div  (.a_i(a_i), .b_i(b_i), .op_i(op_i), .res_o(div_res));

  // bit 0: M group; bit 4 inside it: divider
  assign result_o = !op_i[0] ? base_res : (op_i[4] ? div_res : mul_res);

  function automatic logic known_op(input logic [OP_W-1:0] op);
    unique case (op)
      OP_ADD, OP_SUB, OP_SLL, OP_SLT, OP_SLTU, OP_XOR, OP_SRL, OP_SRA,
      OP_OR, OP_AND, OP_MUL, OP_MULH, OP_MULHU, OP_MULHSU,
      OP_DIV, OP_DIVU, OP_REM, OP_REMU: known_op = 1'b1;
      default: known_op = 1'b0;
    endcase
  endfunction

  localparam logic [XLEN-1:0] MIN_S = {1'b1, {(XLEN-1){1'b0}}};

  always_comb begin
    if ((op_i == OP_SLT) || (op_i == OP_SLTU)) begin
      a_r4_slt_bool: assert (result_o[XLEN-1:1] == '0) else $error("R4 compare not boolean");
    end
    if (((op_i == OP_DIV) || (op_i == OP_DIVU)) && (b_i == '0)) begin
      a_r8_div_zero: assert (result_o == '1) else $error("R8 div by zero");
    end
    if (((op_i == OP_REM) || (op_i == OP_REMU)) && (b_i == '0)) begin
      a_r8_rem_zero: assert (result_o == a_i) else $error("R8 rem by zero");
    end
    if ((op_i == OP_DIV) && (a_i == MIN_S) && (b_i == '1)) begin
      a_r9_div_ovf: assert (result_o == a_i) else $error("R9 div overflow");
    end
    if ((op_i == OP_REM) && (a_i == MIN_S) && (b_i == '1)) begin
      a_r9_rem_ovf: assert (result_o == '0) else $error("R9 rem overflow");
    end
    if (!known_op(op_i)) begin
      a_r10_unused_zero: assert (result_o == '0) else $error("R10 unused code");
    end
  end
endmodule

// File: tb/tb_int_alu.sv
`timescale 1ns/1ps
module tb_int_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b;
  logic [4:0]  op;
  logic [31:0] res;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  int_alu dut (.a_i(a), .b_i(b), .op_i(op), .result_o(res));

  function automatic string req_of(logic [4:0] o, logic [31:0] x, logic [31:0] y);
    case (o)
      5'b00000, 5'b00010: return "R1";
      5'b10000, 5'b11000, 5'b11100: return "R2";
      5'b00100, 5'b10100, 5'b10110: return "R3";
      5'b01000, 5'b01100: return "R4";
      5'b00001: return "R5";
      5'b00101, 5'b01001, 5'b01101: return "R6";
      5'b10001, 5'b10101, 5'b11001, 5'b11101: begin
        if (y == 0) return "R8";
        if (o[3:2] == 2'b00 || o[3:2] == 2'b10)
          if (x == 32'h8000_0000 && y == 32'hFFFF_FFFF) return "R9";
        return "R7";
      end
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] model(logic [4:0] o, logic [31:0] x, logic [31:0] y);
    longint sx = longint'($signed(x));
    longint sy = longint'($signed(y));
    longint ux = longint'({32'b0, x});
    longint uy = longint'({32'b0, y});
    longint t;
    int     s = int'(y % 32);
    case (o)
      5'b00000: t = ux + uy;
      5'b00010: t = ux - uy;
      5'b00100: t = ux * (longint'(1) << s);
      5'b10100: t = ux / (longint'(1) << s);
      5'b10110: begin
        t = sx;
        for (int k = 0; k < s; k++) t = (t - ((t % 2 + 2) % 2)) / 2;
      end
      5'b01000: t = (sx < sy) ? 1 : 0;
      5'b01100: t = (ux < uy) ? 1 : 0;
      5'b10000: t = ux ^ uy;
      5'b11000: t = ux | uy;
      5'b11100: t = ux & uy;
      5'b00001: t = sx * sy;
      5'b00101: t = (sx * sy) >>> 32;
      5'b01001: begin
        logic [63:0] p = {32'b0, x} * {32'b0, y};
        t = longint'(p >> 32);
      end
      5'b01101: t = (sx * uy) >>> 32;
      5'b10001: t = (y == 0) ? -1 : sx / sy;
      5'b10101: t = (y == 0) ? -1 : ux / uy;
      5'b11001: t = (y == 0) ? sx : sx % sy;
      5'b11101: t = (y == 0) ? ux : ux % uy;
      default:  t = 0;
    endcase
    return t[31:0];
  endfunction

  task automatic apply(logic [4:0] o, logic [31:0] x, logic [31:0] y);
    logic [31:0] exp;
    @(negedge clk);
    op = o; a = x; b = y;
    @(posedge clk);
    #1;
    exp = model(o, x, y);
    checks++;
    if (res !== exp) begin
      fails++;
      $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", req_of(o, x, y), o, x, y, res, exp);
    end
  endtask

  logic [31:0] grid [12] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h2, 32'hFFFF_FFFE,
                             32'h8000_0000, 32'h7FFF_FFFF, 32'h1F, 32'h20, 32'h21,
                             32'h1234_5678, 32'hF0F0_0F0F};

  initial begin
    a = '0; b = '0; op = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset-time state: ADD of zeros
    checks++;
    if (res !== 32'h0) begin
      fails++;
      $display("FAIL R1 reset actual=%h expected=%h", res, 32'h0);
    end
    rst_ni = 1'b1;
    // R8 R9 directed edges
    apply(5'b10001, 32'h8000_0000, 32'hFFFF_FFFF);
    apply(5'b11001, 32'h8000_0000, 32'hFFFF_FFFF);
    apply(5'b10101, 32'hDEAD_BEEF, 32'h0);
    apply(5'b11101, 32'hDEAD_BEEF, 32'h0);
    apply(5'b10001, 32'hFFFF_FFF9, 32'h2);   // R7 -7/2 = -3
    apply(5'b11001, 32'hFFFF_FFF9, 32'h2);   // R7 rem -1
    apply(5'b10100, 32'h8000_0000, 32'h24);  // R3 only low 5 bits: shift 4
    apply(5'b10110, 32'h8000_0000, 32'h3F);  // R3 shift 31
    // all codes (R10 included) over the extreme grid
    for (int o = 0; o < 32; o++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          apply(5'(o), grid[i], grid[j]);
    // random operands, every code
    for (int n = 0; n < 2000; n++)
      apply(5'($urandom_range(0, 31)), $urandom, (n % 7 == 0) ? 32'($urandom_range(0, 3)) : $urandom);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule